// File: doc/BRIEF.md
# Scanline Sprite Evaluator and Renderer

This block decides which sprites appear on a raster line and produces their pixels. It walks a 64-entry, 256-byte object attribute memory through a synchronous read port, keeps the first eight entries whose vertical extent covers the requested line, then fetches two pattern bytes (low and high plane) for each kept sprite through a second read port. Each `line_start` pulse starts a new search and at the same moment moves the results of the previous search into the eight render slots. The block therefore always draws the line that was searched one pulse earlier.

While rendering, each slot holds an X down-counter and two 8-bit shifters. On every `pix_en` cycle a slot counts down until its counter reaches zero and then shifts out one pixel per cycle for eight cycles. A fixed-priority selector picks the lowest-numbered slot with a non-zero pixel and outputs its 2-bit pattern value, palette, behind-background bit and whether it is OAM entry 0. Two sticky flags report a ninth sprite on a searched line and a sprite-0 hit against an opaque background pixel. Both clear on `frame_clr`.

The evaluator is a named state machine. In `EV_IDLE` it waits for `line_start`. `EV_OAM_REQ` presents an OAM address. `EV_OAM_CAP` takes the byte: Y is range-tested, and tile, attributes and X are stored. `EV_PAT_REQ` presents a pattern address and `EV_PAT_CAP` stores the byte. The transitions are these:
- IDLE→OAM_REQ on `line_start`, from any state.
- OAM_REQ→OAM_CAP always.
- OAM_CAP→OAM_REQ while entries or bytes remain.
- OAM_CAP→PAT_REQ after entry 63, or on finding a ninth sprite.
- OAM_CAP→IDLE after entry 63 when nothing was found.
- PAT_REQ→PAT_CAP always.
- PAT_CAP→PAT_REQ while bytes remain, and PAT_CAP→IDLE after the high plane of the last kept sprite.

Top module: `spr_line_engine`

## Requirements
- R1: OAM entry n occupies bytes 4n..4n+3 as Y, tile, attributes, X. Attribute bit 7 is vertical flip, bit 6 is horizontal flip, bit 5 is behind-background and bits 1:0 are the palette. Both read ports return data one cycle after the address.
- R2: After `line_start` with line L, `busy` is high from the next cycle until the search ends. A sprite is kept when 0 ≤ L−Y < H, where H is 8, or 16 in tall mode. At most 8 are kept, in ascending OAM order.
- R3: In 8x8 mode the pattern address is {ptbl_hi, tile[7:0], plane, row[2:0]}, with plane 0 for the low byte and plane 1 for the high byte, and row = L−Y.
- R4: When a ninth sprite covers the searched line, `ovf_flag` becomes 1 before `busy` falls, and it stays set.
- R5: In tall mode the address is {tile[0], tile[7:1], row[3], plane, row[2:0]}. Vertical flip uses row = H−1−(L−Y) in both modes.
- R6: After the next `line_start`, a kept sprite shows at pixel x = X+c for c = 0..7, where x counts `pix_en` cycles from 0. The pixel value is {high bit, low bit} taken from bit 7−c, or from bit c under horizontal flip.
- R7: `spr_pix` is the value of the lowest-index kept sprite that is non-zero at that pixel, or 0 when there is none. `spr_pal` and `spr_behind` come from that sprite, and `spr_zero` is 1 only when it is OAM entry 0.
- R8: `hit_flag` becomes 1 after a `pix_en` cycle in which kept entry 0 has a non-zero pixel, `bg_opaque` is 1 and x ≠ 255. It stays set.
- R9: `frame_clr` clears both flags in the next cycle.
- R10: After reset `busy`, both flags and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clr | input | 1 | Clears the overflow and hit flags (pre-render line) |
| line_start | input | 1 | Starts a search and promotes the previous result to the render slots |
| line_num | input | 8 | Line to search for |
| tall_mode | input | 1 | 1 selects 8x16 sprites |
| ptbl_hi | input | 1 | Pattern table select for 8x8 sprites |
| pix_en | input | 1 | Advances one visible pixel |
| bg_opaque | input | 1 | Background pixel at the current x is opaque |
| oam_addr | output | 8 | OAM read address |
| oam_rdata | input | 8 | OAM read data, one cycle latency |
| pat_addr | output | 13 | Pattern read address |
| pat_rdata | input | 8 | Pattern read data, one cycle latency |
| busy | output | 1 | Search or fetch in progress |
| spr_pix | output | 2 | Winning sprite pattern value, 0 means transparent |
| spr_pal | output | 2 | Winning sprite palette |
| spr_behind | output | 1 | Winning sprite sits behind the background |
| spr_zero | output | 1 | Winning sprite is OAM entry 0 |
| ovf_flag | output | 1 | More than 8 sprites on a searched line |
| hit_flag | output | 1 | Sprite-0 hit |

## Verification
A wrong search count, row or address shows up on the first rendered line after the promoting `line_start`, as wrong pixels at the sprite's columns or as a false `ovf_flag` before `busy` falls. A slot whose counter or shifter is wrong moves or corrupts its 8 pixels within that same line. A priority fault shows wherever two sprites overlap. A hit-logic fault shows as a `hit_flag` value that differs from the expected one once the 256 pixels of the line have been driven, including the case of an opaque sprite-0 pixel only at x = 255.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int PAT_AW    = 13;
    localparam int A_VFLIP   = 7;
    localparam int A_HFLIP   = 6;
    localparam int A_BEHIND  = 5;

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_OAM_REQ,
        EV_OAM_CAP,
        EV_PAT_REQ,
        EV_PAT_CAP
    } ev_state_t;
endpackage

// File: rtl/spr_eval_fsm.sv
module spr_eval_fsm
    import spr_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SLOTS   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            line,
    input  logic                  tall,
    input  logic                  ptbl_hi,
    output logic [$clog2(ENTRIES)+1:0] oam_addr,
    input  logic [7:0]            oam_rdata,
    output logic [PAT_AW-1:0]     pat_addr,
    input  logic [7:0]            pat_rdata,
    output logic                  busy,
    output logic [$clog2(SLOTS):0] cnt,
    output logic                  zero_found,
    output logic                  ovf_set,
    output logic [8*SLOTS-1:0]    slot_x,
    output logic [8*SLOTS-1:0]    slot_attr,
    output logic                  pat_we,
    output logic [$clog2(SLOTS)-1:0] pat_slot,
    output logic                  pat_plane,
    output logic [7:0]            pat_byte
);
    localparam int IW = $clog2(ENTRIES);
    localparam int SW = $clog2(SLOTS);

    ev_state_t st, nxt;
    logic [IW-1:0] idx;
    logic [1:0]    k;
    logic [SW-1:0] fs;
    logic          fp;
    logic [7:0]    tile_q [SLOTS];
    logic [7:0]    attr_q [SLOTS];
    logic [7:0]    x_q    [SLOTS];
    logic [3:0]    row_q  [SLOTS];

    logic [8:0] diff;
    logic       y_hit, last_idx, full, last_fetch;
    logic [SW:0] cnt_m1;

    assign diff       = {1'b0, line} - {1'b0, oam_rdata};
    assign y_hit      = !diff[8] && (diff[7:0] < (tall ? 8'd16 : 8'd8));
    assign last_idx   = (idx == IW'(ENTRIES - 1));
    assign full       = (cnt == (SW + 1)'(SLOTS));
    assign cnt_m1     = cnt - 1'b1;
    assign last_fetch = fp && ({1'b0, fs} == cnt_m1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EV_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            EV_IDLE:    nxt = EV_IDLE;
            EV_OAM_REQ: nxt = EV_OAM_CAP;
            EV_OAM_CAP: begin
                if (k == 2'd0) begin
                    if (y_hit)
                        nxt = full ? EV_PAT_REQ : EV_OAM_REQ;
                    else if (last_idx)
                        nxt = (cnt != '0) ? EV_PAT_REQ : EV_IDLE;
                    else
                        nxt = EV_OAM_REQ;
                end else if (k == 2'd3 && last_idx) begin
                    nxt = EV_PAT_REQ;
                end else begin
                    nxt = EV_OAM_REQ;
                end
            end
            EV_PAT_REQ: nxt = EV_PAT_CAP;
            EV_PAT_CAP: nxt = last_fetch ? EV_IDLE : EV_PAT_REQ;
            default:    nxt = EV_IDLE;
        endcase
        if (start) nxt = EV_OAM_REQ;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0; k <= '0; cnt <= '0; fs <= '0; fp <= 1'b0; zero_found <= 1'b0;
            for (int i = 0; i < SLOTS; i++) begin
                tile_q[i] <= '0; attr_q[i] <= '0; x_q[i] <= '0; row_q[i] <= '0;
            end
        end else if (start) begin
            idx <= '0; k <= '0; cnt <= '0; fs <= '0; fp <= 1'b0; zero_found <= 1'b0;
        end else if (st == EV_OAM_CAP) begin
            if (k == 2'd0) begin
                if (y_hit && !full) begin
                    row_q[cnt[SW-1:0]] <= diff[3:0];
                    k <= 2'd1;
                    if (idx == '0) zero_found <= 1'b1;
                end else if (!y_hit) begin
                    idx <= idx + 1'b1;
                end
            end else begin
                unique case (k)
                    2'd1:    tile_q[cnt[SW-1:0]] <= oam_rdata;
                    2'd2:    attr_q[cnt[SW-1:0]] <= oam_rdata;
                    default: x_q[cnt[SW-1:0]]    <= oam_rdata;
                endcase
                if (k == 2'd3) begin
                    cnt <= cnt + 1'b1;
                    idx <= idx + 1'b1;
                end
                k <= k + 1'b1;
            end
        end else if (st == EV_PAT_CAP) begin
            fp <= ~fp;
            if (fp) fs <= fs + 1'b1;
        end
    end

    // outputs
    logic [7:0] f_tile, f_attr;
    logic [3:0] f_row;
    always_comb begin
        f_tile   = tile_q[fs];
        f_attr   = attr_q[fs];
        f_row    = f_attr[A_VFLIP] ? ((tall ? 4'd15 : 4'd7) - row_q[fs]) : row_q[fs];
        pat_addr = tall ? {f_tile[0], f_tile[7:1], f_row[3], fp, f_row[2:0]}
                        : {ptbl_hi, f_tile, fp, f_row[2:0]};
        for (int b = 0; b < 8; b++)
            pat_byte[b] = f_attr[A_HFLIP] ? pat_rdata[7-b] : pat_rdata[b];
        oam_addr  = {idx, k};
        busy      = (st != EV_IDLE);
        ovf_set   = (st == EV_OAM_CAP) && (k == 2'd0) && y_hit && full;
        pat_we    = (st == EV_PAT_CAP);
        pat_slot  = fs;
        pat_plane = fp;
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_flat
        assign slot_x[8*i +: 8]    = x_q[i];
        assign slot_attr[8*i +: 8] = attr_q[i];
    end
endmodule

// File: rtl/spr_slot.sv
module spr_slot
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       promote,
    input  logic       valid_in,
    input  logic [7:0] x_in,
    input  logic [7:0] attr_in,
    input  logic       we_lo,
    input  logic       we_hi,
    input  logic [7:0] byte_in,
    input  logic       pix_en,
    output logic [1:0] pix,
    output logic [1:0] pal,
    output logic       behind
);
    logic [7:0] st_lo, st_hi, sh_lo, sh_hi, xcnt;
    logic       act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_lo <= '0; st_hi <= '0;
        end else begin
            if (we_lo) st_lo <= byte_in;
            if (we_hi) st_hi <= byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_lo <= '0; sh_hi <= '0; xcnt <= '0; act <= 1'b0; pal <= '0; behind <= 1'b0;
        end else if (promote) begin
            sh_lo  <= st_lo;
            sh_hi  <= st_hi;
            xcnt   <= x_in;
            act    <= valid_in;
            pal    <= attr_in[1:0];
            behind <= attr_in[A_BEHIND];
        end else if (pix_en) begin
            if (xcnt != '0) begin
                xcnt <= xcnt - 1'b1;
            end else begin
                sh_lo <= {sh_lo[6:0], 1'b0};
                sh_hi <= {sh_hi[6:0], 1'b0};
            end
        end
    end

    assign pix = (act && xcnt == '0) ? {sh_hi[7], sh_lo[7]} : 2'b00;
endmodule

// File: rtl/spr_prio_mux.sv
module spr_prio_mux #(
    parameter int SLOTS = 8
) (
    input  logic [2*SLOTS-1:0] pix_v,
    input  logic [2*SLOTS-1:0] pal_v,
    input  logic [SLOTS-1:0]   behind_v,
    output logic [1:0]         pix,
    output logic [1:0]         pal,
    output logic               behind,
    output logic               from_first
);
    always_comb begin
        pix = '0; pal = '0; behind = 1'b0; from_first = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (pix_v[2*i +: 2] != 2'b00) begin
                pix        = pix_v[2*i +: 2];
                pal        = pal_v[2*i +: 2];
                behind     = behind_v[i];
                from_first = (i == 0);
            end
        end
    end
endmodule

// File: rtl/spr_line_engine.sv
module spr_line_engine
    import spr_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SLOTS   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_clr,
    input  logic        line_start,
    input  logic [7:0]  line_num,
    input  logic        tall_mode,
    input  logic        ptbl_hi,
    input  logic        pix_en,
    input  logic        bg_opaque,
    output logic [7:0]  oam_addr,
    input  logic [7:0]  oam_rdata,
    output logic [12:0] pat_addr,
    input  logic [7:0]  pat_rdata,
    output logic        busy,
    output logic [1:0]  spr_pix,
    output logic [1:0]  spr_pal,
    output logic        spr_behind,
    output logic        spr_zero,
    output logic        ovf_flag,
    output logic        hit_flag
);
    localparam int SW = $clog2(SLOTS);

    logic [SW:0]          ev_cnt;
    logic                 ev_zero, ovf_set, pat_we, pat_plane;
    logic [SW-1:0]        pat_slot;
    logic [7:0]           pat_byte;
    logic [8*SLOTS-1:0]   slot_x, slot_attr;
    logic [2*SLOTS-1:0]   pix_v, pal_v;
    logic [SLOTS-1:0]     behind_v;
    logic                 win_first, act_zero;
    logic [7:0]           px;

    spr_eval_fsm #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_eval (
        .clk(clk), .rst_n(rst_n), .start(line_start), .line(line_num),
        .tall(tall_mode), .ptbl_hi(ptbl_hi),
        .oam_addr(oam_addr), .oam_rdata(oam_rdata),
        .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .busy(busy), .cnt(ev_cnt), .zero_found(ev_zero), .ovf_set(ovf_set),
        .slot_x(slot_x), .slot_attr(slot_attr),
        .pat_we(pat_we), .pat_slot(pat_slot), .pat_plane(pat_plane), .pat_byte(pat_byte)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        spr_slot u_slot (
            .clk(clk), .rst_n(rst_n), .promote(line_start),
            .valid_in((SW + 1)'(i) < ev_cnt),
            .x_in(slot_x[8*i +: 8]), .attr_in(slot_attr[8*i +: 8]),
            .we_lo(pat_we && pat_slot == SW'(i) && !pat_plane),
            .we_hi(pat_we && pat_slot == SW'(i) && pat_plane),
            .byte_in(pat_byte), .pix_en(pix_en),
            .pix(pix_v[2*i +: 2]), .pal(pal_v[2*i +: 2]), .behind(behind_v[i])
        );
    end

    spr_prio_mux #(.SLOTS(SLOTS)) u_prio (
        .pix_v(pix_v), .pal_v(pal_v), .behind_v(behind_v),
        .pix(spr_pix), .pal(spr_pal), .behind(spr_behind), .from_first(win_first)
    );

    assign spr_zero = win_first && act_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px <= '0; act_zero <= 1'b0; ovf_flag <= 1'b0; hit_flag <= 1'b0;
        end else begin
            if (line_start) begin
                px       <= '0;
                act_zero <= ev_zero;
            end else if (pix_en) begin
                px <= px + 1'b1;
            end
            if (frame_clr)    ovf_flag <= 1'b0;
            else if (ovf_set) ovf_flag <= 1'b1;
            if (frame_clr)
                hit_flag <= 1'b0;
            else if (pix_en && !line_start && px != 8'hFF && act_zero &&
                     pix_v[1:0] != 2'b00 && bg_opaque)
                hit_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/spr_line_engine_chk.sv
module spr_line_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_clr,
    input logic       line_start,
    input logic       busy,
    input logic       pix_en,
    input logic       bg_opaque,
    input logic [7:0] px,
    input logic [1:0] spr_pix,
    input logic       spr_zero,
    input logic       ovf_flag,
    input logic       hit_flag
);
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> busy);                                              // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !frame_clr) |=> ovf_flag);                            // R4
    AST_ZERO_NEEDS_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_pix == 2'b00) |-> !spr_zero);                                 // R7
    AST_HIT_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(px) != 8'hFF && $past(pix_en) && $past(bg_opaque))); // R8
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_flag && !frame_clr) |=> hit_flag);                            // R8
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> (!ovf_flag && !hit_flag));                           // R9
endmodule

bind spr_line_engine spr_line_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .line_start(line_start),
    .busy(busy), .pix_en(pix_en), .bg_opaque(bg_opaque), .px(px),
    .spr_pix(spr_pix), .spr_zero(spr_zero), .ovf_flag(ovf_flag), .hit_flag(hit_flag)
);

// File: tb/spr_line_engine_bench.sv
module spr_line_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clr = 0, line_start = 0, tall_mode = 0, ptbl_hi = 0, pix_en = 0, bg_opaque = 0;
    logic [7:0]  line_num = 0;
    logic [7:0]  oam_addr, oam_rdata = 0, pat_rdata = 0;
    logic [12:0] pat_addr;
    logic busy, spr_behind, spr_zero, ovf_flag, hit_flag;
    logic [1:0] spr_pix, spr_pal;

    logic [7:0] oam [256];
    int n_chk = 0, n_bad = 0, cyc = 0;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    spr_line_engine u_spr_line_engine (.*);

    function automatic logic [7:0] pat_byte(input int a);
        if (((a >> 4) & 8'hFF) == 0) return 8'h00;
        return 8'((a * 29) ^ (a >> 3));
    endfunction

    always @(posedge clk) begin
        oam_rdata <= oam[oam_addr];
        pat_rdata <= pat_byte(int'(pat_addr));
    end

    function automatic bit bg_at(input int x);
        return (x % 3) != 2;
    endfunction

    // pixel of OAM entry i at (line, x), 0 when not covering
    function automatic logic [1:0] ent_pix(input int i, input int line, input int x);
        int y, h, d, col, r, tile, attr, a, b;
        y = oam[4*i]; tile = oam[4*i+1]; attr = oam[4*i+2];
        h = tall_mode ? 16 : 8;
        d = line - y;
        col = x - int'(oam[4*i+3]);
        if (d < 0 || d >= h || col < 0 || col > 7) return 2'b00;
        r = attr[7] ? (h - 1 - d) : d;
        if (tall_mode) a = ((tile & 1) << 12) | (((tile >> 1) << 1 | (r >> 3)) << 4) | (r & 7);
        else           a = (int'(ptbl_hi) << 12) | (tile << 4) | (r & 7);
        b = attr[6] ? col : 7 - col;
        return {pat_byte(a | 8)[b], pat_byte(a)[b]};
    endfunction

    function automatic bit covers(input int i, input int line);
        int d;
        d = line - int'(oam[4*i]);
        return d >= 0 && d < (tall_mode ? 16 : 8);
    endfunction

    function automatic int n_cover(input int line);
        int n = 0;
        for (int i = 0; i < 64; i++) if (covers(i, line)) n++;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int line);
        @(negedge clk); line_start = 1; line_num = 8'(line);
        @(negedge clk); line_start = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic run_line(input int line);
        int n; logic [1:0] p, v, pl; logic bh, z0, hit;
        @(negedge clk); frame_clr = 1;
        @(negedge clk); frame_clr = 0;
        pulse_start(line);
        check("R4 overflow", ovf_flag, n_cover(line) > 8);      // R2 R4
        pulse_start(254);                                        // promotes line
        hit = 0;
        for (int x = 0; x < 256; x++) begin
            @(negedge clk); pix_en = 1; bg_opaque = bg_at(x);
            #1;
            n = 0; p = 0; pl = 0; bh = 0; z0 = 0;
            for (int i = 0; i < 64; i++) begin
                if (covers(i, line) && n < 8) begin
                    n++;
                    v = ent_pix(i, line, x);
                    if (i == 0 && v != 0 && bg_at(x) && x != 255) hit = 1;
                    if (p == 0 && v != 0) begin
                        p = v; pl = oam[4*i+2][1:0]; bh = oam[4*i+2][5]; z0 = (i == 0);
                    end
                end
            end
            // R3 R5 R6 R7: pixel, palette, priority, entry-0 marker
            check("R6 pix", {spr_pix, spr_pal, spr_behind, spr_zero}, {p, pl, bh, z0});
        end
        @(negedge clk); pix_en = 0; #1;
        check("R8 hit", hit_flag, hit);
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 8) % m);
    endfunction

    task automatic fill_rand(input int ybase, input int span);
        for (int i = 0; i < 64; i++) begin
            oam[4*i]   = 8'(ybase + rnd(span));
            oam[4*i+1] = 8'(rnd(256));
            oam[4*i+2] = 8'(rnd(256));
            oam[4*i+3] = 8'(rnd(240));
        end
    endtask

    task automatic clear_oam();
        for (int i = 0; i < 256; i++) oam[i] = 8'hFF;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            finish_run();
        end
    end

    initial begin
        int t;
        clear_oam();
        repeat (3) @(negedge clk);
        #1;
        check("R10 reset", {busy, ovf_flag, hit_flag, spr_pix, spr_zero}, 0);
        rst_n = 1;

        // R1 R2 R3 R6 R7: 8x8 sweep, both tables
        fill_rand(40, 40);
        for (int l = 40; l < 84; l += 4) run_line(l);
        ptbl_hi = 1;
        for (int l = 50; l < 70; l += 5) run_line(l);
        ptbl_hi = 0;

        // R5: tall sprites with flips
        tall_mode = 1;
        fill_rand(40, 40);
        for (int l = 42; l < 90; l += 4) run_line(l);
        tall_mode = 0;

        // R4: exactly 8, then 9 on one line
        clear_oam();
        for (int i = 3; i < 11; i++) begin
            oam[4*i] = 100; oam[4*i+1] = 8'(i * 7 + 1); oam[4*i+2] = 8'(i); oam[4*i+3] = 8'(i * 20);
        end
        run_line(100);
        oam[44] = 95; oam[45] = 9; oam[46] = 0; oam[47] = 30;
        run_line(100);
        // R9: frame_clr clears a set overflow
        pulse_start(100);
        check("R4 set", ovf_flag, 1);
        @(negedge clk); frame_clr = 1;
        @(negedge clk); frame_clr = 0; #1;
        check("R9 clear", {ovf_flag, hit_flag}, 0);

        // R8: entry 0 opaque only at x=255, then reachable
        clear_oam();
        t = 1;
        while (!pat_byte((t << 4) | 0)[7]) t++;
        oam[0] = 120; oam[1] = 8'(t); oam[2] = 0; oam[3] = 255;
        run_line(120);
        check("R8 no hit at 255", hit_flag, 0);
        oam[3] = 240;
        run_line(120);
        finish_run();
    end
endmodule